// File: doc/BRIEF.md
# Length-Checked SPI Register Port

This block is an SPI slave (clock mode 0) that gives a host read and write access to a bank of 32-bit registers. Every transaction is framed by chip select. While chip select is low, the first 32 bits form a header that carries an opcode, a start address and a word count. That many 32-bit data words follow. A write stores them into consecutive registers. A read makes the slave shift consecutive register contents out on MISO.

The slave counts the rising SCLK edges of every frame. When chip select rises, it compares this count against the length declared in the header. A write is committed to the bank only when the count matches. Any mismatch, or a header the slave cannot accept, sets a sticky SPI error flag. The slave reports this flag in a status byte, which is the first thing it shifts out on MISO in every frame.

SCLK, MOSI and chip select are brought into the system clock domain by a two-flop synchronizer. They are then treated as sampled levels, so the system clock must run several times faster than SCLK.

Top module: `lenspi_top`

## Requirements
- R1: The header word is sent MSB first and has three fields. Bits 31:24 hold the opcode: 0x61 means write and 0x41 means read. Bits 23:8 hold a byte address, and register k lives at byte address 4k, so the word index is bits 23:10. Bits 7:0 hold LENGTH, the number of data words that follow.
- R2: A write is committed only if chip select rises after exactly 32 + 32×LENGTH rising SCLK edges. The data then lands in the bank and is visible to the next frame.
- R3: If chip select rises after any other edge count, no register changes and the SPI error flag is set.
- R4: The first 8 bits on MISO after chip select falls form the status byte, sent MSB first. Bit 7 is the global error, bit 5 is the CAN fault, bit 3 is the SPI error, and all other bits are 0. The remaining 24 header-period bits on MISO are 0.
- R5: The global error bit is the OR of the SPI error flag and the `canFault` input.
- R6: Data word k of a frame maps to register start+k, in both directions. Read data is sent MSB first, and MISO changes only after falling SCLK edges.
- R7: The slave rejects a header if LENGTH is 0, LENGTH is greater than MAX_WORDS (default 8), the opcode is unknown, or address bits 9:8 are not zero. A rejected header sets the SPI error at chip-select release, writes nothing, and returns 0 on all data words.
- R8: The register at byte address 0x000C reads as {24'b0, status byte}. A committed write to it with bit 3 set clears the SPI error flag. A write with bit 3 clear leaves the flag as it is.
- R9: `misoEn` is 1 only while the synchronized chip select is low. `miso` is 0 whenever `misoEn` is 0, including after reset.
- R10: Pauses in SCLK while chip select stays low do not change the outcome of a frame. A host that sends the frame as 8-bit or 16-bit pieces gets the same result.
- R11: A register index of NUM_REGS or more reads as 0, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| csN | input | 1 | Active-low chip select |
| canFault | input | 1 | Level-sensitive CAN fault flag reported in the status byte |
| miso | output | 1 | Serial data to the host |
| misoEn | output | 1 | Output enable for the MISO pad driver |

## Verification
The bench builds the block with NUM_REGS=16 and MAX_WORDS=8. With these values, a random start index of 0 to 17 can land on the status register, on the last registers of the bank, and on indexes past the end of the bank. With a length of up to 8, a burst can also run across the top of the bank. Bursts of the full 8 words and a rejected length of 9 can both be reached. Off-by-one and off-by-eight edge counts test the framing check next to the exact count.

// File: rtl/lenspi_pkg.sv
package lenspi_pkg;
  localparam int WORD_W = 32;
  localparam logic [7:0] OP_WR = 8'h61;
  localparam logic [7:0] OP_RD = 8'h41;
  localparam int STATUS_IDX = 3;

  typedef struct packed {
    logic frameStart;
    logic capBit;
    logic shiftOut;
    logic loadWord;
    logic storeData;
    logic commitWr;
    logic errSet;
    logic rdMode;
  } strobe_t;
endpackage

// File: rtl/lenspi_sync.sv
module lenspi_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/lenspi_ctrl.sv
module lenspi_ctrl
  import lenspi_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  localparam int IDXW = 14,
  localparam int BUFW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int CW = $clog2((MAX_WORDS + 1) * WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkS,
  input  logic              csNS,
  input  logic [WORD_W-1:0] nextWord,
  output strobe_t           stb,
  output logic [BUFW-1:0]   bufIdx,
  output logic [IDXW-1:0]   regIdx
);
  logic sclkD, csD;
  logic sclkRise, sclkFall, csFall, csRise;
  logic [CW-1:0] bitCnt;
  logic [CW-6:0] wordNum;
  logic loadNext, hdrOk, isWr, commitActive;
  logic [7:0] lenR;
  logic [IDXW-1:0] curIdx, startIdx;
  logic [BUFW-1:0] commitCnt;
  logic wordEnd, hdrEnd, dataEnd, hValid, frameOk;
  logic [7:0] hOp, hLen;
  logic [CW-1:0] expBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      csD   <= 1'b1;
    end else begin
      sclkD <= sclkS;
      csD   <= csNS;
    end
  end

  assign sclkRise = sclkS & ~sclkD & ~csNS;
  assign sclkFall = ~sclkS & sclkD & ~csNS;
  assign csFall   = ~csNS & csD;
  assign csRise   = csNS & ~csD;

  assign wordNum = bitCnt[CW-1:5];
  assign wordEnd = sclkRise && (bitCnt[4:0] == 5'd31);
  assign hdrEnd  = wordEnd && (wordNum == '0);
  assign dataEnd = wordEnd && (wordNum != '0);
  assign hOp     = nextWord[31:24];
  assign hLen    = nextWord[7:0];
  assign hValid  = ((hOp == OP_WR) || (hOp == OP_RD)) && (hLen != 8'd0) &&
                   (int'(hLen) <= MAX_WORDS) && (nextWord[9:8] == 2'b00);
  assign expBits = CW'((int'(lenR) + 1) * WORD_W);
  assign frameOk = hdrOk && (bitCnt == expBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; loadNext <= 1'b0; hdrOk <= 1'b0; isWr <= 1'b0;
      lenR <= '0; curIdx <= '0; startIdx <= '0;
    end else if (csFall) begin
      bitCnt <= '0; loadNext <= 1'b0; hdrOk <= 1'b0; isWr <= 1'b0;
      lenR <= '0;
    end else begin
      if (sclkRise && (bitCnt != '1)) bitCnt <= bitCnt + 1'b1;
      if (wordEnd) loadNext <= 1'b1;
      else if (sclkFall) loadNext <= 1'b0;
      if (hdrEnd) begin
        hdrOk    <= hValid;
        isWr     <= (hOp == OP_WR);
        lenR     <= hLen;
        curIdx   <= nextWord[23:10];
        startIdx <= nextWord[23:10];
      end else if (dataEnd) begin
        curIdx <= curIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitActive <= 1'b0;
      commitCnt    <= '0;
    end else if (csRise && frameOk && isWr) begin
      commitActive <= 1'b1;
      commitCnt    <= '0;
    end else if (commitActive) begin
      if (int'(commitCnt) == int'(lenR) - 1) commitActive <= 1'b0;
      else commitCnt <= commitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.frameStart = csFall;
    stb.capBit     = sclkRise;
    stb.shiftOut   = sclkFall && !loadNext;
    stb.loadWord   = sclkFall && loadNext;
    stb.storeData  = dataEnd && hdrOk && isWr && (int'(wordNum) <= int'(lenR));
    stb.commitWr   = commitActive;
    stb.errSet     = csRise && !frameOk;
    stb.rdMode     = hdrOk && !isWr;
  end

  assign bufIdx = commitActive ? commitCnt : BUFW'(wordNum - 1'b1);
  assign regIdx = commitActive ? (startIdx + IDXW'(commitCnt)) : curIdx;

  // R2
  commit_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitActive) |-> $past(csRise && frameOk && isWr));
  // R3
  no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && !frameOk) |=> !commitActive);
  // R2
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csFall |=> (bitCnt >= $past(bitCnt)));
  // R7
  hdr_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdrEnd && !hValid) |=> !hdrOk);
endmodule

// File: rtl/lenspi_datapath.sv
module lenspi_datapath
  import lenspi_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int MAX_WORDS = 8,
  localparam int IDXW = 14,
  localparam int BUFW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BUFW-1:0]   bufIdx,
  input  logic [IDXW-1:0]   regIdx,
  input  logic              mosiS,
  input  logic              canFault,
  output logic [WORD_W-1:0] nextWord,
  output logic              misoBit
);
  logic [WORD_W-1:0] shiftIn, shiftReg, rdData;
  logic [WORD_W-1:0] pending [MAX_WORDS];
  logic [WORD_W-1:0] regFile [NUM_REGS];
  logic spiErr, globErr;
  logic [7:0] statusByte;
  logic statSel;

  assign nextWord   = {shiftIn[WORD_W-2:0], mosiS};
  assign globErr    = spiErr | canFault;
  assign statusByte = {globErr, 1'b0, canFault, 1'b0, spiErr, 3'b000};
  assign statSel    = (regIdx == IDXW'(STATUS_IDX));

  always_comb begin
    if (statSel) rdData = {24'b0, statusByte};
    else if (int'(regIdx) < NUM_REGS) rdData = regFile[regIdx[RW-1:0]];
    else rdData = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn  <= '0;
      shiftReg <= '0;
    end else begin
      if (stb.capBit) shiftIn <= nextWord;
      if (stb.frameStart) shiftReg <= {statusByte, 24'b0};
      else if (stb.loadWord) shiftReg <= stb.rdMode ? rdData : '0;
      else if (stb.shiftOut) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < MAX_WORDS; w++) pending[w] <= '0;
    end else if (stb.storeData) begin
      pending[bufIdx] <= nextWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regFile[r] <= '0;
    end else if (stb.commitWr) begin
      for (int r = 0; r < NUM_REGS; r++)
        if ((r != STATUS_IDX) && (regIdx == IDXW'(r))) regFile[r] <= pending[bufIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) spiErr <= 1'b0;
    else if (stb.errSet) spiErr <= 1'b1;
    else if (stb.commitWr && statSel && pending[bufIdx][3]) spiErr <= 1'b0;
  end

  assign misoBit = shiftReg[WORD_W-1];

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.errSet |=> spiErr);
  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiErr) |-> $past(stb.commitWr && statSel));
  // R4
  status_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStart |=> (shiftReg[WORD_W-1:WORD_W-8] == $past(statusByte)));
endmodule

// File: rtl/lenspi_top.sv
module lenspi_top
  import lenspi_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int MAX_WORDS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic mosi,
  input  logic csN,
  input  logic canFault,
  output logic miso,
  output logic misoEn
);
  localparam int IDXW = 14;
  localparam int BUFW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic sclkS, mosiS, csNS, misoBit;
  logic [WORD_W-1:0] nextWord;
  logic [BUFW-1:0] bufIdx;
  logic [IDXW-1:0] regIdx;
  strobe_t stb;

  lenspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, mosi}), .dout({csNS, sclkS, mosiS}));

  lenspi_ctrl #(.MAX_WORDS(MAX_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .csNS(csNS), .nextWord(nextWord),
    .stb(stb), .bufIdx(bufIdx), .regIdx(regIdx));

  lenspi_datapath #(.NUM_REGS(NUM_REGS), .MAX_WORDS(MAX_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .bufIdx(bufIdx), .regIdx(regIdx),
    .mosiS(mosiS), .canFault(canFault), .nextWord(nextWord), .misoBit(misoBit));

  assign misoEn = ~csNS;
  assign miso   = misoEn & misoBit;
endmodule

// File: tb/lenspi_top_test.sv
`timescale 1ns/1ps
module lenspi_top_test;
  localparam int NREG = 16;
  localparam int MAXW = 8;
  localparam int HALF = 5;
  localparam logic [7:0] WR = 8'h61;
  localparam logic [7:0] RD = 8'h41;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, mosi = 1'b0, csN = 1'b1, canFault = 1'b0;
  wire miso, misoEn;
  always #2.5 clk = ~clk;

  lenspi_top #(.NUM_REGS(NREG), .MAX_WORDS(MAXW)) uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .csN(csN),
    .canFault(canFault), .miso(miso), .misoEn(misoEn));

  int checks = 0, fails = 0;
  logic [31:0] mReg [NREG];
  logic mErr = 1'b0;
  logic [31:0] tx [10];
  logic [31:0] rx [10];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mStatus();
    return {mErr | canFault, 1'b0, canFault, 1'b0, mErr, 3'b000};
  endfunction

  function automatic logic [31:0] mRead(input int a);
    if (a == 3) return {24'b0, mStatus()};
    if (a < NREG) return mReg[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] hdr(input logic [7:0] op, input int idx, input int len, input int mis);
    return {op, 14'(idx), 2'(mis), 8'(len)};
  endfunction

  task automatic runFrame(input int nbits, input int gap, input string tag);
    logic [7:0] op;
    int len, idx;
    bit ok, bitsOk;
    logic [31:0] exp;
    op = tx[0][31:24];
    len = int'(tx[0][7:0]);
    idx = int'(tx[0][23:10]);
    ok = ((op == WR) || (op == RD)) && (len >= 1) && (len <= MAXW) && (tx[0][9:8] == 2'b00);
    bitsOk = (nbits == 32 * (len + 1));
    for (int k = 0; k < 10; k++) rx[k] = '0;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    check({tag, " R9 enable low cs"}, {31'b0, misoEn}, 32'd1);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[i / 32][31 - (i % 32)];
      repeat (HALF) @(negedge clk);
      rx[i / 32][31 - (i % 32)] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      if ((gap != 0) && (i % 8 == 7)) repeat (gap) @(negedge clk);
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (30) @(negedge clk);
    check({tag, " R9 enable high cs"}, {30'b0, misoEn, miso}, 32'd0);
    if (nbits >= 32) check({tag, " R4 status word"}, rx[0], {mStatus(), 24'b0});
    for (int k = 1; k < 10; k++) begin
      if (nbits >= 32 * (k + 1)) begin
        exp = (ok && (op == RD)) ? mRead(idx + k - 1) : 32'h0;
        check($sformatf("%s R6 data%0d", tag, k), rx[k], exp);
      end
    end
    if (!(ok && bitsOk)) mErr = 1'b1;
    else if (op == WR) begin
      for (int k = 0; k < len; k++) begin
        if (idx + k == 3) begin
          if (tx[k + 1][3]) mErr = 1'b0;
        end else if (idx + k < NREG) mReg[idx + k] = tx[k + 1];
      end
    end
  endtask

  task automatic wrWords(input int idx, input int len, input string tag);
    tx[0] = hdr(WR, idx, len, 0);
    runFrame(32 * (len + 1), 0, tag);
  endtask

  task automatic rdWords(input int idx, input int len, input string tag);
    tx[0] = hdr(RD, idx, len, 0);
    for (int k = 1; k < 10; k++) tx[k] = '0;
    runFrame(32 * (len + 1), 0, tag);
  endtask

  task automatic clearErr();
    tx[1] = 32'h0000_0008;
    wrWords(3, 1, "R8 clear");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NREG; r++) mReg[r] = '0;
    repeat (10) @(negedge clk);
    check("R9 reset outputs", {30'b0, misoEn, miso}, 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    rdWords(0, 1, "R4 reset read");
    tx[1] = 32'hDEAD_BEEF;
    wrWords(1, 1, "R1 single write");
    rdWords(1, 1, "R1 R2 readback");

    tx[1] = 32'h1111_0001; tx[2] = 32'h2222_0002; tx[3] = 32'h3333_0003;
    wrWords(4, 3, "R6 burst write");
    rdWords(4, 3, "R6 burst read");
    tx[0] = hdr(WR, 8, 8, 0);
    for (int k = 1; k <= 8; k++) tx[k] = 32'hA5A5_0000 + 32'(k);
    runFrame(288, 0, "R2 max burst");
    rdWords(8, 8, "R2 max readback");

    tx[0] = hdr(WR, 2, 1, 0); tx[1] = 32'hCAFE_F00D;
    runFrame(72, 0, "R3 long write");
    rdWords(2, 1, "R3 R4 unchanged");
    tx[0] = hdr(WR, 2, 1, 0); tx[1] = 32'h0BAD_0BAD;
    runFrame(63, 0, "R3 short write");
    tx[1] = 32'h0000_0000;
    wrWords(3, 1, "R8 write zero");
    rdWords(3, 1, "R8 still set");
    clearErr();
    rdWords(3, 1, "R8 cleared");

    tx[0] = hdr(WR, 5, 0, 0); runFrame(32, 0, "R7 len zero");
    rdWords(5, 1, "R7 err after len0");
    clearErr();
    tx[0] = hdr(8'h55, 5, 1, 0); tx[1] = 32'h1;
    runFrame(64, 0, "R7 bad opcode");
    clearErr();
    tx[0] = hdr(RD, 5, 9, 0); runFrame(320, 0, "R7 len over max");
    clearErr();
    tx[0] = hdr(WR, 5, 1, 1); tx[1] = 32'h7777_7777;
    runFrame(64, 0, "R7 misaligned");
    rdWords(5, 1, "R7 no write");
    clearErr();

    canFault = 1'b1;
    rdWords(0, 1, "R5 can fault");
    tx[0] = hdr(RD, 0, 1, 0); runFrame(40, 0, "R5 make err");
    rdWords(3, 1, "R5 both flags");
    clearErr();
    canFault = 1'b0;

    tx[1] = 32'h5A5A_C3C3; tx[2] = 32'h0F0F_1234;
    tx[0] = hdr(WR, 12, 2, 0);
    runFrame(96, 7, "R10 split write");
    tx[0] = hdr(RD, 12, 2, 0);
    runFrame(96, 13, "R10 split read");

    tx[1] = 32'h9999_9999;
    wrWords(20, 1, "R11 write out of range");
    rdWords(20, 1, "R11 read out of range");
    tx[1] = 32'h4444_4444; tx[2] = 32'h5555_5555;
    wrWords(15, 2, "R11 straddle write");
    rdWords(15, 2, "R11 straddle read");

    for (int n = 0; n < 30; n++) begin
      int idx, len, nb, sel;
      logic [7:0] op;
      idx = int'($urandom_range(17, 0));
      len = int'($urandom_range(MAXW, 1));
      op = ($urandom_range(1, 0) == 1) ? WR : RD;
      tx[0] = hdr(op, idx, len, 0);
      for (int k = 1; k < 10; k++) tx[k] = $urandom();
      nb = 32 * (len + 1);
      sel = int'($urandom_range(5, 0));
      if (sel == 0) nb = nb + 1;
      else if (sel == 1) nb = nb - 1;
      else if (sel == 2) nb = nb - 8;
      canFault = ($urandom_range(7, 0) == 0);
      runFrame(nb, (sel == 3) ? 3 : 0, "R2 R3 R6 random");
    end
    canFault = 1'b0;
    for (int r = 0; r < NREG; r += 8) rdWords(r, 8, "R6 final sweep");

    summary();
    $finish;
  end
endmodule